// File: doc/BRIEF.md
# Parallel Panel Bus Timing Controller

This block is a bus master for an asynchronous, SRAM-style parallel bus used to talk to a display panel in 8080 fashion. The bus is 16 bits wide, and address and data are not multiplexed on it. An internal requester hands over one access at a time: a read/write flag, an address and write data. The block plays the access out on the panel pins and then returns a done pulse, along with the captured data for reads. The panel pins are chip select, read strobe, write strobe, a data/command select and the bidirectional data bus.

Every access runs three phases in a fixed order: address setup, then the strobe (data) phase, then bus turnaround. Each phase length comes from a 32-bit timing word and is counted in system clock cycles. There is one timing word for reads and one for writes. When split timing is enabled, writes use the write word, so a panel that reads slowly and writes quickly gets its own lengths for each direction. With split timing off, both directions use the read word.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset, and whenever no access is in progress, bus_cs_n, bus_rd_n and bus_wr_n are high, rsp_done is low, and req_ready is high while cfg_bank_en is set.
- R2: After a request is accepted on a rising edge, bus_cs_n is low with both strobes high for exactly the setup count of cycles. One strobe is then low for exactly the strobe count of cycles, and bus_cs_n and the strobe return high together.
- R3: After bus_cs_n returns high, req_ready stays low for exactly the turnaround count of cycles before the next request can be accepted.
- R4: With cfg_split_timing set, writes use wr_timing and reads use rd_timing. With it clear, both directions use rd_timing.
- R5: Each timing word holds three fields: setup count in bits 3:0, strobe count in bits 15:8 and turnaround count in bits 19:16. Bits 7:4 (hold) and bits 29:28 (access mode) have no effect on bus timing.
- R6: A setup or turnaround count of 0 skips that phase. A strobe count of 0 gives a one-cycle strobe.
- R7: On a write, bus_data carries the write data and bus_dc equals address bit 16 throughout the low time of bus_cs_n. Only bus_wr_n pulses.
- R8: On a read, only bus_rd_n pulses. The block samples bus_data on the last strobe cycle, and rsp_done pulses together with rsp_rdata holding the sample in the first cycle after bus_cs_n rises. The block never drives bus_data during a read.
- R9: With cfg_write_en clear, a write request is consumed without any bus activity: bus_cs_n stays high and rsp_done pulses in the following cycle.
- R10: With cfg_bank_en clear, req_ready is low and a held request is not accepted. bus_cs_n stays high.
- R11: bus_rd_n and bus_wr_n are never low together, and neither is low while bus_cs_n is high.
- R12: With read timing setup 2, strobe 36, turnaround 10 and write timing setup 2, strobe 3, turnaround 3, the bus shows exactly those cycle counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_en | input | 1 | Bank responds to requests when set |
| cfg_write_en | input | 1 | Writes reach the bus when set |
| cfg_split_timing | input | 1 | Writes use their own timing word when set |
| rd_timing | input | 32 | Read timing word (used by both directions when split timing is off) |
| wr_timing | input | 32 | Write timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Access address; bit 16 drives bus_dc |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_done | output | 1 | One-cycle pulse marking the end of an access |
| rsp_rdata | output | DATA_W (16) | Data captured by the last read |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_rd_n | output | 1 | Panel read strobe, active low |
| bus_wr_n | output | 1 | Panel write strobe, active low |
| bus_dc | output | 1 | Panel data/command select |
| bus_data | inout | DATA_W (16) | Panel data bus |

## Verification
The assertions check on every cycle that the two strobes never overlap and never appear outside chip select, and that the block releases the data bus whenever the read strobe is low. They also check that the strobe phase lasts exactly the latched strobe count, that setup only ever leads into the strobe phase, and that a blocked write leaves chip select high. Some properties can only be shown by the bench's scenarios, which measure whole accesses at the pins. These are the exact setup, strobe and turnaround counts for each timing word, the choice between read and write timing words, the indifference to the hold and mode fields, the handling of zero-length fields, the read data that is captured, and the stall while the bank is disabled.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  localparam int SETUP_W = 4;
  localparam int STROBE_W = 8;
  localparam int TURN_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_DATA  = 2'd2,
    PH_TURN  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0]  setup;
    logic [STROBE_W-1:0] strobe;
    logic [TURN_W-1:0]   turn;
  } tset_t;

  // Field positions of a timing word; strobe length is clamped to at least one cycle.
  function automatic tset_t unpack_timing(input logic [31:0] w);
    tset_t t;
    t.setup  = w[3:0];
    t.strobe = (w[15:8] == '0) ? STROBE_W'(1) : w[15:8];
    t.turn   = w[19:16];
    return t;
  endfunction

endpackage

// File: rtl/lbm_timing_sel.sv
module lbm_timing_sel
  import lbm_pkg::*;
(
  input  logic [31:0] rd_word,
  input  logic [31:0] wr_word,
  input  logic        split,
  input  logic        is_write,
  output tset_t       tset
);

  logic        use_wr;
  logic [31:0] chosen;

  assign use_wr = split && is_write;
  assign chosen = use_wr ? wr_word : rd_word;
  assign tset   = unpack_timing(chosen);

endmodule

// File: rtl/lbm_phase_seq.sv
module lbm_phase_seq
  import lbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  tset_t  tset,
  output phase_e phase,
  output logic   last_data
);

  logic [CNT_W-1:0]    cnt;
  logic [STROBE_W-1:0] strobe_q;
  logic [TURN_W-1:0]   turn_q;

  assign last_data = (phase == PH_DATA) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= STROBE_W'(1);
      turn_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            strobe_q <= tset.strobe;
            turn_q   <= tset.turn;
            if (tset.setup != '0) begin
              phase <= PH_SETUP;
              cnt   <= CNT_W'(tset.setup - SETUP_W'(1));
            end else begin
              phase <= PH_DATA;
              cnt   <= CNT_W'(tset.strobe - STROBE_W'(1));
            end
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_DATA;
            cnt   <= CNT_W'(strobe_q - STROBE_W'(1));
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt == '0) begin
            if (turn_q != '0) begin
              phase <= PH_TURN;
              cnt   <= CNT_W'(turn_q - TURN_W'(1));
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // Independent run-length counter for the strobe phase.
  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (phase == PH_DATA && !last_data) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_data |-> (run_len + CNT_W'(1) == CNT_W'(strobe_q)));

  assert_setup_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_DATA));

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lbm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 17,
  parameter int DC_BIT = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bank_en,
  input  logic              cfg_write_en,
  input  logic              cfg_split_timing,
  input  logic [31:0]       rd_timing,
  input  logic [31:0]       wr_timing,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_dc,
  inout  wire  [DATA_W-1:0] bus_data
);

  tset_t       tset_live;
  phase_e      phase;
  logic        last_data;
  logic        accept;
  logic        blocked_wr;
  logic        start;
  logic        wr_q;
  logic        dc_q;
  logic [DATA_W-1:0] wdata_q;
  logic        in_cs;
  logic        drive_en;

  lbm_timing_sel u_sel (
    .rd_word  (rd_timing),
    .wr_word  (wr_timing),
    .split    (cfg_split_timing),
    .is_write (req_write),
    .tset     (tset_live)
  );

  lbm_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tset      (tset_live),
    .phase     (phase),
    .last_data (last_data)
  );

  assign req_ready  = cfg_bank_en && (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign blocked_wr = accept && req_write && !cfg_write_en;
  assign start      = accept && !blocked_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      dc_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      dc_q    <= req_addr[DC_BIT];
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= blocked_wr || last_data;
      if (last_data && !wr_q) rsp_rdata <= bus_data;
    end
  end

  assign in_cs    = (phase == PH_SETUP) || (phase == PH_DATA);
  assign bus_cs_n = !in_cs;
  assign bus_rd_n = !((phase == PH_DATA) && !wr_q);
  assign bus_wr_n = !((phase == PH_DATA) && wr_q);
  assign bus_dc   = dc_q;
  assign drive_en = wr_q && in_cs;
  assign bus_data = drive_en ? wdata_q : {DATA_W{1'bz}};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n));

  assert_strobe_in_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (!bus_cs_n && (bus_rd_n || bus_wr_n)));

  assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> bus_rd_n);

  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !cfg_write_en) |=> (bus_cs_n && rsp_done));

endmodule

// File: tb/lcd_bus_master_bench.sv
module lcd_bus_master_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_bank_en = 1'b1;
  logic        cfg_write_en = 1'b1;
  logic        cfg_split_timing = 1'b1;
  logic [31:0] rd_timing = 32'h000A_2402;
  logic [31:0] wr_timing = 32'h0003_0302;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_wr_n, bus_dc;
  logic [15:0] rsp_rdata;
  logic [15:0] panel_val = 16'h0000;
  wire  [15:0] pbus;

  assign pbus = (!bus_rd_n) ? panel_val : 16'hzzzz;

  lcd_bus_master u_lcd_bus_master (
    .clk(clk), .rst_n(rst_n),
    .cfg_bank_en(cfg_bank_en), .cfg_write_en(cfg_write_en),
    .cfg_split_timing(cfg_split_timing),
    .rd_timing(rd_timing), .wr_timing(wr_timing),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dc(bus_dc), .bus_data(pbus)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    int          setup;
    int          strobe;
    int          turn;
    bit          rd;
    logic [15:0] data;
    logic        dc;
    string       tag;
  } exp_t;

  exp_t q[$];

  // Driver: expectations come from the timing-word layout of R5 and the rules of R4/R6.
  task automatic access(input bit wr, input logic [16:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    logic [31:0] w;
    w = (wr && cfg_split_timing) ? wr_timing : rd_timing;
    e.setup  = int'(w & 32'hF);
    e.strobe = int'((w >> 8) & 32'hFF);
    if (e.strobe == 0) e.strobe = 1;
    e.turn   = int'((w >> 16) & 32'hF);
    e.rd     = !wr;
    e.data   = wr ? d : panel_val;
    e.dc     = a[16];
    e.tag    = tag;
    q.push_back(e);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: measures each access at the pins and compares with the queue head.
  bit   in_acc = 0, in_turn = 0, bad_kind = 0, bad_data = 0;
  int   su = 0, st = 0, tu = 0;
  exp_t cur;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!in_acc && !in_turn && !bus_cs_n) begin
          if (q.size() == 0) begin
            check(0, "R10 unexpected access", 1, 0);
            cur.setup = 0; cur.strobe = 0; cur.turn = 0; cur.rd = 1; cur.data = '0; cur.dc = 0; cur.tag = "R2";
          end else cur = q[0];
          in_acc = 1; su = 0; st = 0; bad_kind = 0; bad_data = 0;
        end
        if (in_acc) begin
          if (!bus_cs_n) begin
            if (bus_rd_n && bus_wr_n) begin
              if (st != 0) bad_kind = 1;
              su++;
            end else begin
              st++;
              if (cur.rd && !bus_wr_n) bad_kind = 1;
              if (!cur.rd && !bus_rd_n) bad_kind = 1;
            end
            if (!cur.rd && pbus !== cur.data) bad_data = 1;
            if (bus_dc !== cur.dc) bad_data = 1;
          end else begin
            in_acc = 0;
            check(su == cur.setup, {cur.tag, " setup cycles (R2)"}, su, cur.setup);
            check(st == cur.strobe, {cur.tag, " strobe cycles (R2)"}, st, cur.strobe);
            check(!bad_kind, "R11 strobe kind/order", int'(bad_kind), 0);
            check(!bad_data, "R7 data/dc during chip select", int'(bad_data), 0);
            check(rsp_done == 1'b1, "R8 done after access", int'(rsp_done), 1);
            if (cur.rd) check(rsp_rdata == cur.data, "R8 read data", int'(rsp_rdata), int'(cur.data));
            in_turn = 1; tu = 0;
          end
        end
        if (in_turn) begin
          if (!req_ready) tu++;
          else begin
            in_turn = 0;
            check(tu == cur.turn, {cur.tag, " turnaround cycles (R3)"}, tu, cur.turn);
            if (q.size() != 0) void'(q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle high", int'({bus_cs_n, bus_rd_n, bus_wr_n}), 7);
    check(req_ready == 1'b1 && rsp_done == 1'b0, "R1 ready/done", int'({req_ready, rsp_done}), 2);

    // R12: programmed panel timings, split mode
    access(1'b1, 17'h1_0000, 16'hA5C3, "R12 write");
    panel_val = 16'h3C5A;
    access(1'b0, 17'h1_0004, 16'h0000, "R12 read");
    access(1'b1, 17'h0_0002, 16'h1234, "R7 command write");

    // R4: split off -> writes use the read timing word
    cfg_split_timing = 1'b0;
    access(1'b1, 17'h1_0001, 16'hBEEF, "R4 write");
    cfg_split_timing = 1'b1;
    // R4: split on with a different read word
    rd_timing = 32'h0005_0A01;
    panel_val = 16'h0F0F;
    access(1'b0, 17'h0_0003, 16'h0000, "R4 read");

    // R5: hold field and mode field set, no effect
    rd_timing = 32'h300A_24F2;
    wr_timing = 32'h2003_03F2;
    panel_val = 16'h8001;
    access(1'b0, 17'h1_0000, 16'h0000, "R5 read");
    access(1'b1, 17'h0_0000, 16'h7E7E, "R5 write");

    // R6: all-zero fields
    rd_timing = 32'h0000_0000;
    wr_timing = 32'h0000_0000;
    panel_val = 16'hC0DE;
    access(1'b0, 17'h1_0000, 16'h0000, "R6 read");
    access(1'b1, 17'h0_0000, 16'h5555, "R6 write");

    rd_timing = 32'h000A_2402;
    wr_timing = 32'h0003_0302;

    // R9: write blocked
    cfg_write_en = 1'b0;
    req_write = 1'b1; req_addr = 17'h1_0000; req_wdata = 16'hFFFF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_done == 1'b1, "R9 done on blocked write", int'(rsp_done), 1);
    check(bus_cs_n == 1'b1, "R9 chip select stays high", int'(bus_cs_n), 1);
    @(negedge clk);
    check(bus_cs_n && req_ready && !rsp_done, "R9 back to idle", int'({bus_cs_n, req_ready, rsp_done}), 6);
    cfg_write_en = 1'b1;

    // R10: bank disabled stalls the request
    cfg_bank_en = 1'b0;
    req_write = 1'b0; req_valid = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_ready || !bus_cs_n || rsp_done) bad = 1;
    end
    req_valid = 1'b0;
    check(!bad, "R10 no acceptance while bank off", int'(bad), 0);
    cfg_bank_en = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after re-enable", int'(req_ready), 1);

    panel_val = 16'h2468;
    access(1'b0, 17'h0_0010, 16'h0000, "R12 read again");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule